// File: doc/BRIEF.md
# Priority-Controlled Universal Shift Register

This block is a small multifunction register of `WIDTH` bits (4 by default). On every rising clock edge it does one of four things: it keeps its value, takes a parallel word, shifts one place toward the low end, or shifts one place toward the high end. The caller drives three independent request lines: load, shift-right and shift-left. A small combinational encoder resolves them with a fixed priority into a 2-bit select. Load beats shift-right, and shift-right beats shift-left.

Each stored bit has its own 4-input multiplexer in front of its flip-flop, steered by that select. The select values are 00 hold, 01 load, 10 shift right and 11 shift left. The clock is never gated. A hold feeds each flip-flop's own output back through its multiplexer. Two serial inputs supply the bit that enters at the vacant end during a shift.

Bit `WIDTH-1` is the leftmost (most significant) bit and bit 0 the rightmost. A synchronous, active-high reset clears the register.

Top module: `prio_shift_reg`

## Requirements
- R1: While `rst` is high at a rising edge, `q_out` becomes all zeros at that edge, whatever the other inputs are.
- R2: With `load_en`, `shr_en` and `shl_en` all low at an edge, `q_out` keeps its previous value.
- R3: With `load_en` high at an edge, `q_out` takes `par_in`. This holds whatever the values of `shr_en` and `shl_en`.
- R4: With `load_en` low and `shr_en` high, bit i takes the old bit i+1 for i below `WIDTH-1`, and the MSB takes `shr_ser`. For example, 1001 shifted right four times with `shr_ser`=0 passes through 0100, 0010, 0001 and 0000.
- R5: With `load_en` and `shr_en` low and `shl_en` high, bit i takes the old bit i-1 for i above 0, and bit 0 takes `shl_ser`.
- R6: With `load_en` low and both `shr_en` and `shl_en` high, the register performs the right shift of R4 and not the left shift.
- R7: A serial input has no effect on `q_out` unless its own shift is the operation selected at that edge. `shr_ser` is ignored during hold, load and left shift, and `shl_ser` is ignored during hold, load and right shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to all zeros |
| load_en | input | 1 | Parallel-load request (highest priority) |
| shr_en | input | 1 | Shift-right request (middle priority) |
| shl_en | input | 1 | Shift-left request (lowest priority) |
| par_in | input | WIDTH | Parallel data word |
| shr_ser | input | 1 | Bit entering the MSB on a right shift |
| shl_ser | input | 1 | Bit entering the LSB on a left shift |
| q_out | output | WIDTH | Registered contents |

## Verification
On every cycle, the assertions compare each next value of `q_out` with the operation that the three request lines call for. They cover reset clearing, holding, loading against any shift request, both shift directions with the correct fill bit, and right over left when both shifts are asked. Multi-step behaviour can only be shown by the bench's directed scenarios. That includes a word draining out over four right shifts, a pattern rotating back in through the serial inputs, and the unused serial input toggling without disturbing the result.

// File: rtl/prio_shift_pkg.sv
package prio_shift_pkg;

  // Multiplexer select shared by the encoder and every bit cell.
  typedef enum logic [1:0] {
    SEL_HOLD = 2'b00,
    SEL_LOAD = 2'b01,
    SEL_SHR  = 2'b10,
    SEL_SHL  = 2'b11
  } sel_t;

endpackage

// File: rtl/prio_shift_enc.sv
module prio_shift_enc
  import prio_shift_pkg::*;
(
  input  logic load_en,
  input  logic shr_en,
  input  logic shl_en,
  output sel_t sel
);

  logic s_hi;
  logic s_lo;

  // Sum-of-products form of the priority table: load > shift right > shift left.
  assign s_hi = (~load_en & ~shr_en &  shl_en)
              | (~load_en &  shr_en & ~shl_en)
              | (~load_en &  shr_en &  shl_en);
  assign s_lo = (~load_en & ~shr_en &  shl_en) | load_en;

  assign sel = sel_t'({s_hi, s_lo});

endmodule

// File: rtl/prio_shift_cell.sv
module prio_shift_cell
  import prio_shift_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  sel_t sel,
  input  logic par_bit,
  input  logic from_hi,
  input  logic from_lo,
  output logic q
);

  logic d;

  // Four-way selector ahead of the flip-flop; hold recirculates q.
  always_comb begin
    case (sel)
      SEL_HOLD: d = q;
      SEL_LOAD: d = par_bit;
      SEL_SHR:  d = from_hi;
      default:  d = from_lo;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= d;
  end

endmodule

// File: rtl/prio_shift_reg.sv
module prio_shift_reg
  import prio_shift_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_en,
  input  logic             shr_en,
  input  logic             shl_en,
  input  logic [WIDTH-1:0] par_in,
  input  logic             shr_ser,
  input  logic             shl_ser,
  output logic [WIDTH-1:0] q_out
);

  localparam int MSB = WIDTH - 1;

  sel_t             sel;
  logic [WIDTH-1:0] q_r;

  prio_shift_enc u_enc (
    .load_en (load_en),
    .shr_en  (shr_en),
    .shl_en  (shl_en),
    .sel     (sel)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic hi_src;
    logic lo_src;

    if (i == MSB) begin : g_top
      assign hi_src = shr_ser;
    end else begin : g_mid_hi
      assign hi_src = q_r[i+1];
    end

    if (i == 0) begin : g_bot
      assign lo_src = shl_ser;
    end else begin : g_mid_lo
      assign lo_src = q_r[i-1];
    end

    prio_shift_cell u_cell (
      .clk     (clk),
      .rst     (rst),
      .sel     (sel),
      .par_bit (par_in[i]),
      .from_hi (hi_src),
      .from_lo (lo_src),
      .q       (q_r[i])
    );
  end

  assign q_out = q_r;

endmodule

// File: rtl/prio_shift_chk.sv
module prio_shift_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             load_en,
  input logic             shr_en,
  input logic             shl_en,
  input logic [WIDTH-1:0] par_in,
  input logic             shr_ser,
  input logic             shl_ser,
  input logic [WIDTH-1:0] q_out
);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> q_out == '0);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!load_en && !shr_en && !shl_en) |=> q_out == $past(q_out));

  // R3
  load_wins_chk: assert property (@(posedge clk) disable iff (rst)
    load_en |=> q_out == $past(par_in));

  // R4
  shift_right_chk: assert property (@(posedge clk) disable iff (rst)
    (!load_en && shr_en) |=> q_out == {$past(shr_ser), $past(q_out[WIDTH-1:1])});

  // R5
  shift_left_chk: assert property (@(posedge clk) disable iff (rst)
    (!load_en && !shr_en && shl_en) |=> q_out == {$past(q_out[WIDTH-2:0]), $past(shl_ser)});

  // R6
  right_over_left_chk: assert property (@(posedge clk) disable iff (rst)
    (!load_en && shr_en && shl_en) |=> q_out[WIDTH-1] == $past(shr_ser));

endmodule

bind prio_shift_reg prio_shift_chk #(.WIDTH(WIDTH)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .load_en (load_en),
  .shr_en  (shr_en),
  .shl_en  (shl_en),
  .par_in  (par_in),
  .shr_ser (shr_ser),
  .shl_ser (shl_ser),
  .q_out   (q_out)
);

// File: tb/tb_prio_shift_reg.sv
module tb_prio_shift_reg;

  localparam int W = 4;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst;
  logic         load_en, shr_en, shl_en;
  logic [W-1:0] par_in;
  logic         shr_ser, shl_ser;
  logic [W-1:0] q_out;

  int  n_vec = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  logic [W-1:0] model;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_shift_reg #(.WIDTH(W)) dut (
    .clk(clk), .rst(rst), .load_en(load_en), .shr_en(shr_en), .shl_en(shl_en),
    .par_in(par_in), .shr_ser(shr_ser), .shl_ser(shl_ser), .q_out(q_out)
  );

  task automatic check(input string tag, input logic [W-1:0] exp);
    n_vec++;
    if (q_out !== exp) begin
      n_bad++;
      $display("FAIL %s: q_out=%b expected=%b", tag, q_out, exp);
    end
  endtask

  // One clock: drive at negedge, compute the expectation from the
  // requirement priorities, check just after the rising edge.
  task automatic cycle(input string tag, input logic r, input logic ld,
                       input logic sr, input logic sl, input logic [W-1:0] p,
                       input logic si_r, input logic si_l);
    @(negedge clk);
    rst = r; load_en = ld; shr_en = sr; shl_en = sl;
    par_in = p; shr_ser = si_r; shl_ser = si_l;
    if (r)       model = '0;
    else if (ld) model = p;
    else if (sr) model = {si_r, model[W-1:1]};
    else if (sl) model = {model[W-2:0], si_l};
    @(posedge clk);
    #1;
    check(tag, model);
  endtask

  task automatic t_reset;
    cycle("R1 reset clears", 1, 1, 1, 1, 4'b1111, 1, 1);
    cycle("R1 reset again", 1, 0, 0, 0, 4'b0000, 0, 0);
  endtask

  task automatic t_load;
    cycle("R3 load 1010", 0, 1, 0, 0, 4'b1010, 0, 0);
    cycle("R3 load with shr", 0, 1, 1, 0, 4'b0110, 1, 0);
    cycle("R3 load with shl", 0, 1, 0, 1, 4'b1100, 0, 1);
    cycle("R3 load with both shifts", 0, 1, 1, 1, 4'b0011, 1, 1);
  endtask

  task automatic t_hold;
    cycle("R3 load 0101", 0, 1, 0, 0, 4'b0101, 0, 0);
    cycle("R2 hold", 0, 0, 0, 0, 4'b1111, 0, 0);
    cycle("R2 hold 2", 0, 0, 0, 0, 4'b0000, 0, 0);
    cycle("R7 hold ignores serials", 0, 0, 0, 0, 4'b1010, 1, 1);
  endtask

  task automatic t_shr;
    cycle("R3 load 1001", 0, 1, 0, 0, 4'b1001, 0, 0);
    cycle("R4 shr 1", 0, 0, 1, 0, 4'b0000, 0, 0);
    cycle("R4 shr 2", 0, 0, 1, 0, 4'b0000, 0, 0);
    cycle("R4 shr 3", 0, 0, 1, 0, 4'b0000, 0, 0);
    cycle("R4 shr 4", 0, 0, 1, 0, 4'b0000, 0, 0);
    cycle("R4 shr fill 1", 0, 0, 1, 0, 4'b0000, 1, 0);
    cycle("R4 shr fill 1b", 0, 0, 1, 0, 4'b0000, 1, 0);
    cycle("R7 shr ignores shl_ser", 0, 0, 1, 0, 4'b0000, 0, 1);
  endtask

  task automatic t_shl;
    cycle("R3 load 0001", 0, 1, 0, 0, 4'b0001, 0, 0);
    cycle("R5 shl 1", 0, 0, 0, 1, 4'b0000, 0, 0);
    cycle("R5 shl 2", 0, 0, 0, 1, 4'b0000, 0, 1);
    cycle("R5 shl 3", 0, 0, 0, 1, 4'b0000, 0, 1);
    cycle("R7 shl ignores shr_ser", 0, 0, 0, 1, 4'b0000, 1, 0);
    cycle("R5 shl 5", 0, 0, 0, 1, 4'b0000, 1, 1);
  endtask

  task automatic t_both;
    cycle("R3 load 0110", 0, 1, 0, 0, 4'b0110, 0, 0);
    cycle("R6 both shifts go right", 0, 0, 1, 1, 4'b0000, 1, 0);
    cycle("R6 both shifts go right 2", 0, 0, 1, 1, 4'b1111, 0, 1);
    cycle("R6 both shifts go right 3", 0, 0, 1, 1, 4'b0000, 1, 1);
  endtask

  task automatic t_load_ignores_serial;
    cycle("R7 load ignores serials", 0, 1, 1, 1, 4'b1000, 0, 1);
    cycle("R7 load ignores serials 2", 0, 1, 0, 1, 4'b0001, 1, 0);
    cycle("R1 reset mid-run", 1, 0, 1, 0, 4'b0000, 1, 0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: run did not complete, actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    rst = 1'b1; load_en = 1'b0; shr_en = 1'b0; shl_en = 1'b0;
    par_in = '0; shr_ser = 1'b0; shl_ser = 1'b0;
    model = '0;
    repeat (2) @(posedge clk);
    t_reset();
    t_load();
    t_hold();
    t_shr();
    t_shl();
    t_both();
    t_load_ignores_serial();
    finish_run();
  end

endmodule